// File: doc/BRIEF.md
# Whole-Page Hamming ECC Engine

This engine watches a flash data bus as a full page goes by and builds a single-error-correcting, double-error-detecting Hamming code over the whole data area. The code is one 16-bit parity word and one 16-bit complement word, which is four check bytes. On a program operation, software clears the engine, sends the data, reads the two words back and stores them as the page's check bytes. On a read operation, the stored check bytes follow the data straight away. The engine folds them into its accumulators, so the parity and complement registers end up holding the syndrome.

When the last check beat has gone by, the engine classifies the syndrome into one of four outcomes: clean, one flipped data bit, one flipped check bit, or more errors than it can correct. For a data error, the parity register gives the failing word and bit, so software can make the repair in its own buffer. The bus may be 8 or 16 bits wide. There are four page geometries, each with 512 << n data bytes plus a spare area of one thirty-second of that size.

Top module: `ecc_page_engine`

## Requirements
- R1: After reset, the status, parity, complement and mode registers all read zero.
- R2: A data beat is a beat with `bus_valid` high and both latch strobes low. Beat k of a page has word address k. Each set data bit at word w, bit b has location L = w*16 + b. The parity register reads the XOR of L over all set bits, and the complement register reads the XOR of (~L & 0xFFFF) over all set bits. In 8-bit mode only `bus_data[7:0]` counts.
- R3: A beat with `bus_cle` or `bus_ale` high leaves the accumulators and the beat counter unchanged.
- R4: Writing register 0 with bit 0 set clears both accumulators, the status flags and the beat counter at the next edge.
- R5: After the data beats, the check beats are folded in. In 8-bit mode there are four of them: parity low byte, parity high byte, complement low byte, complement high byte. In 16-bit mode there are two: parity word, then complement word. When the stored code matches, status reads 0 and both registers read 0.
- R6: The status register (address 2) has bit 0 for error seen, bit 1 for check-code error and bit 2 for multiple error. If the syndrome of every parity bit disagrees with its complement bit, status reads 1 and the parity register reads the location {word[11:0], bit[3:0]}.
- R7: If exactly one of the 32 syndrome bits is set, status reads 3.
- R8: Any other nonzero syndrome makes status read 5. The check-code flag and the multiple flag are never set together.
- R9: An erased page, with all data and check bytes at 0xFF, gives status 5 with the parity register reading 0xFFFF.
- R10: Mode register (address 1) bit 4 selects the 16-bit bus. In that mode, word addresses count 16-bit beats and bit offsets run from 0 to 15.
- R11: Mode bits [1:0] = n select 512 << n data bytes. The check beats are taken right after that many data bytes. The page then runs on through the spare bytes (one thirty-second of the data size).
- R12: The flags update only on the last check beat. They hold through spare beats and idle cycles, and clear on the first beat of the next page.
- R13: If a clear write and a data beat fall in the same cycle, the clear wins and the beat is dropped. The next beat is then word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus beat is present this cycle |
| bus_cle | input | 1 | Command latch strobe for this beat |
| bus_ale | input | 1 | Address latch strobe for this beat |
| bus_data | input | 16 | Beat data (low byte only in 8-bit mode) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 mode, 2 status, 3 parity, 4 complement |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |

## Verification
Two functions can fall in the same cycle: a control clear and a data beat. The bench drives both in the middle of a page. It then checks that parity, complement and status all read zero. It also checks that the next beat (0x0001) lands as word 0, which is seen when the complement register reads 0xFFFF. A reference model, updated beat by beat, is compared against all three registers after every beat and every register write. This covers the fold-in of check beats, the latching of the flags and their clearing on the next page.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    // Bus and location geometry
    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = 4;
    localparam int WORD_W = 12;
    localparam int LOC_W  = BIT_W + WORD_W;
    localparam int CNT_W  = 13;
    localparam int SIZE_W = 2;

    // Register indices
    localparam int REG_CTRL = 0;
    localparam int REG_MODE = 1;
    localparam int REG_STAT = 2;
    localparam int REG_PAR  = 3;
    localparam int REG_CPAR = 4;
    localparam int WIDE_BIT = 4;

    typedef struct packed {
        logic mul;
        logic chk;
        logic rec;
    } ecc_flags_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LOC_W-1:0]  par;
        logic [LOC_W-1:0]  cpar;
        ecc_flags_t        flags;
        logic [SIZE_W-1:0] size;
        logic              wide;
    } ecc_state_t;
endpackage

// File: rtl/ecc_page_geometry.sv
module ecc_page_geometry
    import ecc_pkg::*;
#(
    parameter int BASE_BYTES  = 512,
    parameter int CHECK_BYTES = 4,
    parameter int SPARE_SHIFT = 5
) (
    input  logic [SIZE_W-1:0] size,
    input  logic              wide,
    output logic [CNT_W-1:0]  data_beats,
    output logic [CNT_W-1:0]  check_beats,
    output logic [CNT_W-1:0]  page_beats
);
    localparam int BW = CNT_W + 1;

    logic [BW-1:0] data_bytes;
    logic [BW-1:0] total_bytes;

    always_comb begin
        data_bytes  = BW'(BASE_BYTES) << size;
        total_bytes = data_bytes + (data_bytes >> SPARE_SHIFT);
        if (wide) begin
            data_beats  = CNT_W'(data_bytes >> 1);
            page_beats  = CNT_W'(total_bytes >> 1);
            check_beats = CNT_W'(CHECK_BYTES / 2);
        end else begin
            data_beats  = CNT_W'(data_bytes);
            page_beats  = CNT_W'(total_bytes);
            check_beats = CNT_W'(CHECK_BYTES);
        end
    end
endmodule

// File: rtl/ecc_beat_parity.sv
module ecc_beat_parity
    import ecc_pkg::*;
(
    input  logic [BUS_W-1:0]  data,
    input  logic              wide,
    input  logic [WORD_W-1:0] word,
    output logic [LOC_W-1:0]  p_inc,
    output logic [LOC_W-1:0]  n_inc
);
    logic [BUS_W-1:0] masked;
    logic             beat_par;

    assign masked   = wide ? data : {{(BUS_W-BYTE_W){1'b0}}, data[BYTE_W-1:0]};
    assign beat_par = ^masked;

    // Bit-offset part of the location: split bits by one index bit
    for (genvar k = 0; k < BIT_W; k++) begin : g_bitpos
        logic [BUS_W-1:0] hi_m;
        for (genvar j = 0; j < BUS_W; j++) begin : g_mask
            assign hi_m[j] = 1'(j >> k);
        end
        assign p_inc[k] = ^(masked & hi_m);
        assign n_inc[k] = ^(masked & ~hi_m);
    end

    // Word-address part: whole-beat parity routed by address bit
    for (genvar m = 0; m < WORD_W; m++) begin : g_wordpos
        assign p_inc[BIT_W+m] = word[m] & beat_par;
        assign n_inc[BIT_W+m] = ~word[m] & beat_par;
    end
endmodule

// File: rtl/ecc_syndrome_class.sv
module ecc_syndrome_class
    import ecc_pkg::*;
(
    input  logic [LOC_W-1:0] sp,
    input  logic [LOC_W-1:0] sn,
    output ecc_flags_t       flags
);
    localparam int SW = 2 * LOC_W;

    logic [SW-1:0] syn;
    logic          nonzero;
    logic          single;
    logic          data_err;

    always_comb begin
        syn      = {sn, sp};
        nonzero  = |syn;
        single   = nonzero && ((syn & (syn - SW'(1))) == '0);
        data_err = ((sp ^ sn) == '1);
        flags.rec = nonzero;
        flags.chk = nonzero && !data_err && single;
        flags.mul = nonzero && !data_err && !single;
    end
endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
    import ecc_pkg::*;
#(
    parameter int BASE_DATA_BYTES = 512,
    parameter int REG_AW          = 3,
    parameter int REG_DW          = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_cle,
    input  logic              bus_ale,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata
);
    ecc_state_t st_q, st_d;

    logic [CNT_W-1:0] data_beats, check_beats, page_beats;
    logic [CNT_W-1:0] idx;
    logic [LOC_W-1:0] inc_p, inc_n;
    logic [LOC_W-1:0] chk_p, chk_n;
    logic [LOC_W-1:0] acc_p, acc_n;
    ecc_flags_t       cls;
    logic             beat, clr, mode_wr, fresh, in_data, in_chk, last_chk;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[REG_DW-1:WIDE_BIT+1] ^ ^reg_wdata[WIDE_BIT-1:SIZE_W];

    ecc_page_geometry #(.BASE_BYTES(BASE_DATA_BYTES)) u_geom (
        .size        (st_q.size),
        .wide        (st_q.wide),
        .data_beats  (data_beats),
        .check_beats (check_beats),
        .page_beats  (page_beats)
    );

    ecc_beat_parity u_par (
        .data  (bus_data),
        .wide  (st_q.wide),
        .word  (st_q.cnt[WORD_W-1:0]),
        .p_inc (inc_p),
        .n_inc (inc_n)
    );

    ecc_syndrome_class u_cls (
        .sp    (acc_p),
        .sn    (acc_n),
        .flags (cls)
    );

    // Beat decode and accumulator update values
    always_comb begin
        beat     = bus_valid && !bus_cle && !bus_ale;
        clr      = reg_we && (reg_addr == REG_AW'(REG_CTRL)) && reg_wdata[0];
        mode_wr  = reg_we && (reg_addr == REG_AW'(REG_MODE));
        fresh    = (st_q.cnt == '0);
        in_data  = (st_q.cnt < data_beats);
        in_chk   = !in_data && (st_q.cnt < (data_beats + check_beats));
        idx      = st_q.cnt - data_beats;
        last_chk = in_chk && (idx == (check_beats - CNT_W'(1)));

        chk_p = '0;
        chk_n = '0;
        if (in_chk) begin
            if (st_q.wide) begin
                if (idx == CNT_W'(0))      chk_p = bus_data;
                else if (idx == CNT_W'(1)) chk_n = bus_data;
            end else begin
                case (idx[1:0])
                    2'd0:    chk_p[BYTE_W-1:0]      = bus_data[BYTE_W-1:0];
                    2'd1:    chk_p[LOC_W-1:BYTE_W]  = bus_data[BYTE_W-1:0];
                    2'd2:    chk_n[BYTE_W-1:0]      = bus_data[BYTE_W-1:0];
                    default: chk_n[LOC_W-1:BYTE_W]  = bus_data[BYTE_W-1:0];
                endcase
            end
        end

        acc_p = (fresh ? '0 : st_q.par)  ^ (in_data ? inc_p : '0) ^ chk_p;
        acc_n = (fresh ? '0 : st_q.cpar) ^ (in_data ? inc_n : '0) ^ chk_n;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (beat) begin
            st_d.par   = acc_p;
            st_d.cpar  = acc_n;
            st_d.flags = fresh ? '0 : st_q.flags;
            if (last_chk) st_d.flags = cls;
            st_d.cnt   = (st_q.cnt == (page_beats - CNT_W'(1))) ? '0 : st_q.cnt + CNT_W'(1);
        end
        if (mode_wr) begin
            st_d.size = reg_wdata[SIZE_W-1:0];
            st_d.wide = reg_wdata[WIDE_BIT];
        end
        if (clr) begin
            st_d.cnt   = '0;
            st_d.par   = '0;
            st_d.cpar  = '0;
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(REG_MODE): begin
                reg_rdata[SIZE_W-1:0] = st_q.size;
                reg_rdata[WIDE_BIT]   = st_q.wide;
            end
            REG_AW'(REG_STAT): reg_rdata[2:0]       = st_q.flags;
            REG_AW'(REG_PAR):  reg_rdata[LOC_W-1:0] = st_q.par;
            REG_AW'(REG_CPAR): reg_rdata[LOC_W-1:0] = st_q.cpar;
            default:           reg_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/ecc_page_engine_chk.sv
module ecc_page_engine_chk
    import ecc_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_cle,
    input logic              bus_ale,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              clr_bit,
    input ecc_state_t        st
);
    // R4
    clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_AW'(REG_CTRL) && clr_bit)
        |=> (st.par == '0 && st.cpar == '0 && st.cnt == '0 && st.flags == '0));

    // R3
    latch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && (bus_cle || bus_ale) && !reg_we)
        |=> ($stable(st.par) && $stable(st.cpar) && $stable(st.cnt)));

    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !reg_we) |=> $stable(st.flags));

    // R8
    flag_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st.flags.mul, st.flags.chk}));

    // R7
    flag_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st.flags.mul || st.flags.chk) |-> st.flags.rec);
endmodule

bind ecc_page_engine ecc_page_engine_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_cle   (bus_cle),
    .bus_ale   (bus_ale),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .clr_bit   (reg_wdata[0]),
    .st        (st_q)
);

// File: tb/ecc_page_engine_test.sv
module ecc_page_engine_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_cle, bus_ale;
    logic [15:0] bus_data;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    always #4 clk = ~clk;

    ecc_page_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cle(bus_cle),
        .bus_ale(bus_ale), .bus_data(bus_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    int m_p, m_n, m_cnt, m_flags, m_size;
    bit m_wide;

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int f_data();
        int b = 512 << m_size;
        return m_wide ? b / 2 : b;
    endfunction
    function automatic int f_chk();
        return m_wide ? 2 : 4;
    endfunction
    function automatic int f_total();
        int b = 512 << m_size;
        return m_wide ? (b + b / 32) / 2 : b + b / 32;
    endfunction

    function automatic void model_clear();
        m_p = 0; m_n = 0; m_cnt = 0; m_flags = 0;
    endfunction

    function automatic void model_beat(input logic [15:0] d, input bit cl, input bit al);
        int idx;
        if (cl || al) return;
        if (m_cnt == 0) begin m_p = 0; m_n = 0; m_flags = 0; end
        if (m_cnt < f_data()) begin
            for (int j = 0; j < (m_wide ? 16 : 8); j++) begin
                if (d[j]) begin
                    int l = (m_cnt << 4) | j;
                    m_p ^= l;
                    m_n ^= (~l) & 'hFFFF;
                end
            end
        end else if (m_cnt < f_data() + f_chk()) begin
            idx = m_cnt - f_data();
            if (m_wide) begin
                if (idx == 0) m_p ^= int'(d); else m_n ^= int'(d);
            end else begin
                case (idx)
                    0: m_p ^= int'(d[7:0]);
                    1: m_p ^= int'(d[7:0]) << 8;
                    2: m_n ^= int'(d[7:0]);
                    default: m_n ^= int'(d[7:0]) << 8;
                endcase
            end
            if (idx == f_chk() - 1) begin
                if ((m_p | m_n) == 0) m_flags = 0;
                else if ((m_p ^ m_n) == 'hFFFF) m_flags = 1;
                else if ($countones({m_n[15:0], m_p[15:0]}) == 1) m_flags = 3;
                else m_flags = 5;
            end
        end
        m_cnt = (m_cnt == f_total() - 1) ? 0 : m_cnt + 1;
    endfunction

    task automatic rd(input int a, output int v);
        reg_addr = 3'(a);
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic compare_all(input string tag);
        int v;
        rd(2, v); check({tag, " R12 status"}, v, m_flags);
        rd(3, v); check({tag, " R2 parity"}, v, m_p);
        rd(4, v); check({tag, " R2 complement"}, v, m_n);
    endtask

    task automatic beat(input logic [15:0] d, input bit cl, input bit al, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_data = d; bus_cle = cl; bus_ale = al;
        @(posedge clk);
        #0.5;
        bus_valid = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0;
        model_beat(d, cl, al);
        compare_all(tag);
    endtask

    task automatic wreg(input int a, input int v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = v;
        @(posedge clk);
        #0.5;
        reg_we = 1'b0;
        if (a == 0 && v[0]) model_clear();
        if (a == 1) begin m_size = v & 3; m_wide = v[4]; end
        compare_all("wreg");
    endtask

    function automatic void code_of(input logic [15:0] data[$], input bit wide,
                                    output int p, output int n);
        p = 0; n = 0;
        foreach (data[i]) begin
            for (int j = 0; j < (wide ? 16 : 8); j++) begin
                if (data[i][j]) begin
                    int l = (i << 4) | j;
                    p ^= l;
                    n ^= (~l) & 'hFFFF;
                end
            end
        end
    endfunction

    function automatic void fill(input int count, input int seed, output logic [15:0] q[$]);
        q = {};
        for (int i = 0; i < count; i++) begin
            int v = ((i * 37 + seed) ^ (i >> 3)) & (m_wide ? 'hFFFF : 'hFF);
            q.push_back(16'(v));
        end
    endfunction

    task automatic run_page(input logic [15:0] data[$], input int fw[$], input int fb[$],
                            input int chk_flip, input bit ff_code, input int latch_at,
                            input string tag);
        int cp, cn, v;
        logic [15:0] sent[$];
        logic [15:0] w;
        code_of(data, m_wide, cp, cn);
        sent = data;
        foreach (fw[k]) begin
            w = sent[fw[k]];
            w[fb[k]] = ~w[fb[k]];
            sent[fw[k]] = w;
        end
        for (int i = 0; i < sent.size(); i++) begin
            if (i == latch_at) begin
                beat(16'h00A5, 1'b1, 1'b0, "R3");
                beat(16'h0033, 1'b0, 1'b1, "R3");
            end
            beat(sent[i], 1'b0, 1'b0, tag);
        end
        if (fw.size() == 0) begin
            rd(3, v); check("R2 data parity", v, cp);
            rd(4, v); check("R2 data complement", v, cn);
        end
        if (ff_code) begin cp = 'hFFFF; cn = 'hFFFF; end
        if (chk_flip >= 0) begin
            if (chk_flip < 16) cp ^= 1 << chk_flip;
            else cn ^= 1 << (chk_flip - 16);
        end
        if (m_wide) begin
            beat(16'(cp), 1'b0, 1'b0, tag);
            beat(16'(cn), 1'b0, 1'b0, tag);
        end else begin
            beat({8'h0, 8'(cp)}, 1'b0, 1'b0, tag);
            beat({8'h0, 8'(cp >> 8)}, 1'b0, 1'b0, tag);
            beat({8'h0, 8'(cn)}, 1'b0, 1'b0, tag);
            beat({8'h0, 8'(cn >> 8)}, 1'b0, 1'b0, tag);
        end
        for (int i = 0; i < f_total() - f_data() - f_chk(); i++)
            beat(16'hFFFF, 1'b0, 1'b0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] pg[$];
        int none[$];
        int v;
        none = {};
        rst_n = 1'b0; bus_valid = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0;
        bus_data = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_size = 0; m_wide = 1'b0; model_clear();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #0.5;

        // R1 reset state
        rd(2, v); check("R1 status", v, 0);
        rd(3, v); check("R1 parity", v, 0);
        rd(4, v); check("R1 complement", v, 0);
        rd(1, v); check("R1 mode", v, 0);

        // R5 clean page with latch beats inserted (R3)
        wreg(0, 1);
        fill(512, 11, pg);
        run_page(pg, none, none, -1, 1'b0, 10, "R5");
        rd(2, v); check("R5 status", v, 0);
        rd(3, v); check("R5 syndrome parity", v, 0);
        rd(4, v); check("R5 syndrome complement", v, 0);

        // R6 single data error
        fill(512, 23, pg);
        run_page(pg, '{300}, '{5}, -1, 1'b0, -1, "R6");
        rd(2, v); check("R6 status", v, 1);
        rd(3, v); check("R6 location", v, 'h12C5);
        rd(4, v); check("R6 complement", v, 'hED3A);
        repeat (5) @(posedge clk);
        #0.5;
        rd(2, v); check("R12 idle hold", v, 1);
        wreg(0, 1);
        rd(2, v); check("R4 status cleared", v, 0);
        rd(3, v); check("R4 parity cleared", v, 0);

        // R7 single check-code error
        fill(512, 5, pg);
        run_page(pg, none, none, 9, 1'b0, -1, "R7");
        rd(2, v); check("R7 status", v, 3);
        rd(3, v); check("R7 parity", v, 'h0200);
        beat(16'h0042, 1'b0, 1'b0, "R12");
        rd(2, v); check("R12 next page clears", v, 0);
        wreg(0, 1);

        // R8 two data errors
        fill(512, 77, pg);
        run_page(pg, '{10, 200}, '{1, 6}, -1, 1'b0, -1, "R8");
        rd(2, v); check("R8 status", v, 5);

        // R9 erased page
        pg = {};
        for (int i = 0; i < 512; i++) pg.push_back(16'h00FF);
        run_page(pg, none, none, -1, 1'b1, -1, "R9");
        rd(2, v); check("R9 status", v, 5);
        rd(3, v); check("R9 location", v, 'hFFFF);

        // R10 16-bit bus
        wreg(1, 'h10);
        wreg(0, 1);
        fill(256, 3, pg);
        run_page(pg, '{100}, '{12}, -1, 1'b0, -1, "R10");
        rd(2, v); check("R10 status", v, 1);
        rd(3, v); check("R10 location", v, 'h064C);

        // R11 second page size, error beyond the first 512 bytes
        wreg(1, 1);
        rd(1, v); check("R11 mode readback", v, 1);
        fill(1024, 9, pg);
        run_page(pg, '{1000}, '{3}, -1, 1'b0, -1, "R11");
        rd(2, v); check("R11 status", v, 1);
        rd(3, v); check("R11 location", v, 'h3E83);

        // R13 clear and beat in the same cycle
        wreg(1, 0);
        wreg(0, 1);
        for (int i = 0; i < 5; i++) beat(16'(i + 1), 1'b0, 1'b0, "R13");
        @(negedge clk);
        bus_valid = 1'b1; bus_data = 16'h0001;
        reg_we = 1'b1; reg_addr = 3'(0); reg_wdata = 1;
        @(posedge clk); #0.5;
        bus_valid = 1'b0; reg_we = 1'b0;
        model_clear();
        compare_all("R13");
        rd(3, v); check("R13 parity after collision", v, 0);
        rd(4, v); check("R13 complement after collision", v, 0);
        beat(16'h0001, 1'b0, 1'b0, "R13");
        rd(4, v); check("R13 first word at zero", v, 'hFFFF);
        rd(3, v); check("R13 first word parity", v, 0);

        finish_run();
    end
endmodule